// File: doc/BRIEF.md
# Sixteen-Pin Parallel I/O Port with Peripheral Override

This block is a 16-pin general-purpose parallel port. The pins form two 8-pin halves. Each pin has an output value latch, a drive-enable bit and an override-enable bit. Software reaches these three registers through a simple register write path. That path supports whole-word writes, writes to one half only, and masked writes that change selected bits inside one half. The pin inputs pass through a two-stage synchronizer. The synchronized levels can be read back, and they always feed the peripheral input path.

When a pin's override bit is set, a peripheral takes part in driving that pin. Its data is ANDed with the latch, so software holds the latch at 1 to let the peripheral data pass unchanged. On most pins the drive-enable bit still controls direction. A parameter marks some pins as self-steering. On those pins, when the override is on, the peripheral's own per-cycle enable controls the output driver. This lets the pin turn around every cycle, for example address out and data in on a shared bus.

Top module: `parPort16`

## Requirements
- R1: After reset, the latch, drive-enable and override registers all read 0, and every `pinOe` and `pinOut` bit is 0.
- R2: A write with `wrKind`=0 replaces the whole register chosen by `wrSel` (0 latch, 1 drive-enable, 2 override; 3 selects nothing). A write with `wrKind`=3 changes nothing.
- R3: A write with `wrKind`=1 loads `wrData[7:0]` into the half chosen by `wrHalf` (0 = bits 7:0, 1 = bits 15:8). The other half of that register keeps its value.
- R4: A write with `wrKind`=2 loads `wrData[7:0]` only into the bits of the chosen half where `wrMask` is 1. All other bits keep their value. For example, mask 0x05 with data 0x05 on half 0 sets bits 0 and 2 only.
- R5: On a pin without override, `pinOe` equals its drive-enable bit. If the latch was loaded while the driver was off, `pinOut` shows the latch value in the same cycle that `pinOe` rises.
- R6: On a pin that is not marked in `AUTO_DIR`, `pinOe` follows the drive-enable bit even when the override is set. `altOeIn` has no effect on such a pin.
- R7: On a pin marked in `AUTO_DIR` with the override set, `pinOe` follows `altOeIn` in every cycle and the drive-enable bit is ignored.
- R8: `pinOut` equals latch AND `altOut` on pins with the override set, and equals the latch on all other pins.
- R9: A level on `pinIn` appears on the synchronized value after exactly two rising clock edges. `rdSel`=0 reads the synchronized value.
- R10: `altIn` always equals the synchronized pin value, whatever the drive-enable and override settings.
- R11: `rdData` returns the drive-enable register for `rdSel`=1, the override register for `rdSel`=2 and the latch for `rdSel`=3. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Target register: 0 latch, 1 drive-enable, 2 override |
| wrKind | input | 2 | 0 word, 1 half, 2 masked field, 3 none |
| wrHalf | input | 1 | Half selected for half and field writes |
| wrMask | input | 8 | Bit mask for field writes |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read source select |
| rdData | output | 16 | Read data |
| pinIn | input | 16 | Pad input levels |
| pinOut | output | 16 | Pad output values |
| pinOe | output | 16 | Pad output enables |
| altOut | input | 16 | Peripheral output data |
| altOeIn | input | 16 | Peripheral per-cycle drive enable |
| altIn | output | 16 | Synchronized input to the peripheral |

## Verification
The bench writes one half and then checks that the other half kept its value. A decoder that smeared byte enables across both halves would show up there. A masked write with a sparse mask must leave the unmasked bits alone; a design that wrote the full byte would clear them. `altOeIn` is toggled every cycle on both ordinary and self-steering pins. A mux that ignored `AUTO_DIR` would then either leak the toggling onto ordinary pins or freeze the self-steering ones. The input is sampled one edge and then two edges after a change, which catches a synchronizer with one stage too few or one too many.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_HALF_W = 8;
  localparam int PIO_HALVES = 2;
  localparam int PIO_W      = PIO_HALF_W * PIO_HALVES;
  localparam int PIO_NREG   = 3;

  typedef enum logic [1:0] {
    WK_WORD  = 2'd0,
    WK_HALF  = 2'd1,
    WK_FIELD = 2'd2,
    WK_NONE  = 2'd3
  } wrKind_e;

  typedef struct packed {
    logic [PIO_NREG-1:0] regHit;
    logic [PIO_W-1:0]    bitEn;
    logic [PIO_W-1:0]    bitVal;
  } pioStrobe_t;
endpackage

// File: rtl/pioCtrl.sv
module pioCtrl
  import pio_pkg::*;
(
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [1:0]            wrKind,
  input  logic                  wrHalf,
  input  logic [PIO_HALF_W-1:0] wrMask,
  input  logic [PIO_W-1:0]      wrData,
  output pioStrobe_t            strb
);
  wrKind_e kind;
  logic    doWrite;

  assign kind    = wrKind_e'(wrKind);
  assign doWrite = wrEn && (kind != WK_NONE);

  always_comb begin
    strb.regHit = '0;
    if (doWrite && (int'(wrSel) < PIO_NREG))
      strb.regHit[wrSel] = 1'b1;
  end

  for (genvar h = 0; h < PIO_HALVES; h++) begin : g_half
    logic halfHit;
    assign halfHit = (int'(wrHalf) == h);
    always_comb begin
      unique case (kind)
        WK_WORD: begin
          strb.bitEn[h*PIO_HALF_W +: PIO_HALF_W]  = '1;
          strb.bitVal[h*PIO_HALF_W +: PIO_HALF_W] = wrData[h*PIO_HALF_W +: PIO_HALF_W];
        end
        WK_HALF: begin
          strb.bitEn[h*PIO_HALF_W +: PIO_HALF_W]  = halfHit ? '1 : '0;
          strb.bitVal[h*PIO_HALF_W +: PIO_HALF_W] = wrData[PIO_HALF_W-1:0];
        end
        WK_FIELD: begin
          strb.bitEn[h*PIO_HALF_W +: PIO_HALF_W]  = halfHit ? wrMask : '0;
          strb.bitVal[h*PIO_HALF_W +: PIO_HALF_W] = wrData[PIO_HALF_W-1:0];
        end
        default: begin
          strb.bitEn[h*PIO_HALF_W +: PIO_HALF_W]  = '0;
          strb.bitVal[h*PIO_HALF_W +: PIO_HALF_W] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pioData.sv
module pioData
  import pio_pkg::*;
#(
  parameter logic [PIO_W-1:0] AUTO_DIR = 16'h00FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  pioStrobe_t       strb,
  input  logic [1:0]       rdSel,
  output logic [PIO_W-1:0] rdData,
  input  logic [PIO_W-1:0] pinIn,
  output logic [PIO_W-1:0] pinOut,
  output logic [PIO_W-1:0] pinOe,
  input  logic [PIO_W-1:0] altOut,
  input  logic [PIO_W-1:0] altOeIn,
  output logic [PIO_W-1:0] altIn
);
  localparam int REG_LATCH = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_ALT   = 2;

  logic [PIO_W-1:0] regQ [PIO_NREG];
  logic [PIO_W-1:0] syncA, syncB;

  for (genvar k = 0; k < PIO_NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regQ[k] <= '0;
      else if (strb.regHit[k])
        regQ[k] <= (regQ[k] & ~strb.bitEn) | (strb.bitVal & strb.bitEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PIO_W; i++) begin : g_pin
    logic altOn;
    assign altOn     = regQ[REG_ALT][i];
    assign pinOut[i] = altOn ? (regQ[REG_LATCH][i] & altOut[i]) : regQ[REG_LATCH][i];
    if (AUTO_DIR[i]) begin : g_auto
      assign pinOe[i] = altOn ? altOeIn[i] : regQ[REG_DIR][i];
    end else begin : g_plain
      assign pinOe[i] = regQ[REG_DIR][i];
      // R6
      ordinary_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($stable(regQ[REG_DIR][i]) && !$stable(altOeIn[i])) |-> $stable(pinOe[i]));
    end
    // R8
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      !regQ[REG_LATCH][i] |-> !pinOut[i]);
  end

  assign altIn = syncB;

  always_comb begin
    unique case (rdSel)
      2'd0:    rdData = syncB;
      2'd1:    rdData = regQ[REG_DIR];
      2'd2:    rdData = regQ[REG_ALT];
      default: rdData = regQ[REG_LATCH];
    endcase
  end

  // R2
  reg_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.regHit));

  // R3
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regHit[REG_LATCH] |=>
      ((regQ[REG_LATCH] & ~$past(strb.bitEn)) == ($past(regQ[REG_LATCH]) & ~$past(strb.bitEn))));

  // R4
  field_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.regHit[REG_DIR] |=>
      ((regQ[REG_DIR] & $past(strb.bitEn)) == ($past(strb.bitVal) & $past(strb.bitEn))));

  logic [1:0] syncAge;
  always_ff @(posedge clk) begin
    if (!rstN)                syncAge <= '0;
    else if (syncAge != 2'd2) syncAge <= syncAge + 2'd1;
  end
  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncAge == 2'd2) |-> (syncB == $past(pinIn, 2)));
endmodule

// File: rtl/parPort16.sv
module parPort16
  import pio_pkg::*;
#(
  parameter logic [PIO_W-1:0] AUTO_DIR = 16'h00FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [1:0]            wrKind,
  input  logic                  wrHalf,
  input  logic [PIO_HALF_W-1:0] wrMask,
  input  logic [PIO_W-1:0]      wrData,
  input  logic [1:0]            rdSel,
  output logic [PIO_W-1:0]      rdData,
  input  logic [PIO_W-1:0]      pinIn,
  output logic [PIO_W-1:0]      pinOut,
  output logic [PIO_W-1:0]      pinOe,
  input  logic [PIO_W-1:0]      altOut,
  input  logic [PIO_W-1:0]      altOeIn,
  output logic [PIO_W-1:0]      altIn
);
  pioStrobe_t strb;

  pioCtrl uCtrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrKind (wrKind),
    .wrHalf (wrHalf),
    .wrMask (wrMask),
    .wrData (wrData),
    .strb   (strb)
  );

  pioData #(.AUTO_DIR(AUTO_DIR)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .altOut  (altOut),
    .altOeIn (altOeIn),
    .altIn   (altIn)
  );
endmodule

// File: tb/sim_parPort16.sv
module sim_parPort16;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrSel, wrKind, rdSel;
  logic        wrHalf;
  logic [7:0]  wrMask;
  logic [15:0] wrData, rdData, pinIn, pinOut, pinOe, altOut, altOeIn, altIn;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  parPort16 u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrKind(wrKind),
    .wrHalf(wrHalf), .wrMask(wrMask), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altOut(altOut), .altOeIn(altOeIn), .altIn(altIn)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [1:0] kind, input logic half,
                         input logic [7:0] mask, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrKind = kind; wrHalf = half; wrMask = mask; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] val);
    rdSel = sel;
    #1 val = rdData;
  endtask

  task automatic tReset;
    logic [15:0] v;
    readReg(2'd3, v); check("R1 latch", v, 16'h0000);
    readReg(2'd1, v); check("R1 dir", v, 16'h0000);
    readReg(2'd2, v); check("R1 alt", v, 16'h0000);
    check("R1 pinOe", pinOe, 16'h0000);
    check("R1 pinOut", pinOut, 16'h0000);
  endtask

  task automatic tWord;
    logic [15:0] v;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'hA5C3);
    readReg(2'd3, v); check("R2 R11 latch word", v, 16'hA5C3);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'h1234);
    readReg(2'd2, v); check("R2 R11 alt word", v, 16'h1234);
    doWrite(2'd2, 2'd3, 1'b0, 8'hFF, 16'hFFFF);
    readReg(2'd2, v); check("R2 kind none", v, 16'h1234);
    doWrite(2'd3, 2'd0, 1'b0, 8'hFF, 16'hFFFF);
    readReg(2'd3, v); check("R2 sel none latch", v, 16'hA5C3);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'h0000);
  endtask

  task automatic tHalf;
    logic [15:0] v;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'h1234);
    doWrite(2'd0, 2'd1, 1'b1, 8'h00, 16'h00AB);
    readReg(2'd3, v); check("R3 high half", v, 16'hAB34);
    doWrite(2'd0, 2'd1, 1'b0, 8'h00, 16'hFFCD);
    readReg(2'd3, v); check("R3 low half", v, 16'hABCD);
    doWrite(2'd1, 2'd1, 1'b0, 8'h00, 16'h00FF);
    readReg(2'd1, v); check("R3 R11 dir half", v, 16'h00FF);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h0000);
  endtask

  task automatic tField;
    logic [15:0] v;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'h0000);
    doWrite(2'd0, 2'd2, 1'b0, 8'h05, 16'h0005);
    readReg(2'd3, v); check("R4 mask 05", v, 16'h0005);
    doWrite(2'd0, 2'd2, 1'b1, 8'hF0, 16'h003C);
    readReg(2'd3, v); check("R4 high field", v, 16'h3005);
    doWrite(2'd0, 2'd2, 1'b0, 8'h05, 16'h00F1);
    readReg(2'd3, v); check("R4 partial clear", v, 16'h3001);
    doWrite(2'd1, 2'd2, 1'b1, 8'h81, 16'hFFFF);
    readReg(2'd1, v); check("R4 dir field", v, 16'h8100);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h0000);
  endtask

  task automatic tPreload;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'h00F0);
    #1 check("R5 driver off", pinOe, 16'h0000);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'hFFFF);
    #1 check("R5 oe rises", pinOe, 16'hFFFF);
    check("R5 value with oe", pinOut, 16'h00F0);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h0000);
  endtask

  task automatic tAltOrdinary;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'hFFFF);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'hF000);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'hFF00);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      altOeIn = (c % 2 == 0) ? 16'hFFFF : 16'h0000;
      #1 check("R6 plain oe", pinOe & 16'hFF00, 16'hF000);
    end
  endtask

  task automatic tAltAuto;
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h000F);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'h00FF);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      altOeIn = (c % 2 == 0) ? 16'h00A0 : 16'h005A;
      #1 check("R7 auto oe", pinOe & 16'h00FF, altOeIn & 16'h00FF);
    end
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'h0000);
    #1 check("R7 auto off", pinOe & 16'h00FF, 16'h000F);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h0000);
    altOeIn = 16'h0000;
  endtask

  task automatic tMerge;
    doWrite(2'd0, 2'd0, 1'b0, 8'h00, 16'h0F0F);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'hFFFF);
    altOut = 16'h00FF;
    #1 check("R8 and merge", pinOut, 16'h000F);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'hFF00);
    #1 check("R8 partial override", pinOut, 16'h000F & 16'hFF00 | 16'h0F0F & 16'h00FF);
    doWrite(2'd2, 2'd0, 1'b0, 8'h00, 16'h0000);
    #1 check("R8 latch only", pinOut, 16'h0F0F);
  endtask

  task automatic tSync;
    logic [15:0] v;
    @(negedge clk); pinIn = 16'h0000;
    repeat (3) @(negedge clk);
    pinIn = 16'h5A5A;
    @(negedge clk);
    readReg(2'd0, v); check("R9 one edge", v, 16'h0000);
    @(negedge clk);
    readReg(2'd0, v); check("R9 two edges", v, 16'h5A5A);
    check("R10 alt input", altIn, 16'h5A5A);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'hFFFF);
    pinIn = 16'hC3C3;
    repeat (2) @(negedge clk);
    #1 check("R10 alt input driving", altIn, 16'hC3C3);
    doWrite(2'd1, 2'd0, 1'b0, 8'h00, 16'h0000);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = 2'd0; wrKind = 2'd0; wrHalf = 1'b0;
    wrMask = 8'h00; wrData = 16'h0000; rdSel = 2'd0;
    pinIn = 16'hFFFF; altOut = 16'hFFFF; altOeIn = 16'hFFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    altOeIn = 16'h0000;
    tWord();
    tHalf();
    tField();
    tPreload();
    tAltOrdinary();
    tAltAuto();
    tMerge();
    tSync();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #40000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule